// File: doc/BRIEF.md
# Encoder-Inverse Error Watch with Decoder Wake-Up

This block sits in front of a convolutional (Viterbi) decoder for a rate-1/2, constraint-length-7 code and lets that decoder stay powered down while the channel is clean. It receives the hard-decision coded stream one bit per valid cycle, pairs the bits, and undoes the encoder. A local six-stage copy of the encoder register is XOR-ed with each received coded bit, and this gives two independent estimates of the message bit. When the two estimates match, the bit is delivered directly and no decoder work is needed.

When the estimates differ, the block raises a one-cycle error flag and moves into the awake mode. It signals the decoder to run. It then replays the recent received pairs from a circular history, oldest first, and forwards any pairs that arrive later. When the decoder reports completion together with its final register state, the local register is loaded with that state and direct decoding resumes. A saturating counter records how many wake-ups have taken place.

Top module: `cc_bypass_detect`

## Requirements
- R1: A coded pair is two consecutive valid input bits. The first bit after reset, and every second bit after it, is the lower bit, and the bit that follows is the upper bit. With local register stages s1..s6 (s1 newest), estimate A = lower ^ s1 ^ s2 ^ s3 ^ s6 and estimate B = upper ^ s2 ^ s3 ^ s5 ^ s6. If A equals B in bypass mode, `msg_valid` pulses in the cycle after the upper bit and `msg_bit` equals A.
- R2: Every bit accepted in bypass shifts into the local register as stage s1, and older stages move up one place. Long clean runs therefore decode correctly bit by bit.
- R3: If A differs from B in bypass mode, then in the cycle after the upper bit `err_flag` is high for exactly one cycle, `dec_active` rises, and `msg_valid` stays low.
- R4: Starting the cycle after `err_flag`, `dec_pvalid` presents buffered pairs one per cycle on `dec_pair` (bit 0 = lower, bit 1 = upper), oldest first. The replay holds min(pairs received since reset, DEPTH) pairs and ends with the pair that raised the error.
- R5: Pairs that arrive while `dec_active` is high are appended to the history and forwarded on `dec_pair` after the replayed pairs, in arrival order.
- R6: While `dec_active` is high, `msg_valid` stays low, and a mismatching pair raises neither `err_flag` nor the wake-up count.
- R7: When `dec_done` is high during awake mode, `dec_active` falls in the next cycle, the local register takes the value of `dec_state` (bit 0 = s1), and any pairs not yet forwarded are dropped.
- R8: `wake_cnt` increments by one on each bypass-to-awake transition and holds at 2^CNT_W-1 once it reaches that value.
- R9: Synchronous active-low reset clears the local register, the history, the pair phase and the count, and drives every output to zero.
- R10: If both bits of a pair are corrupted, the two estimates still agree. The inverted bit is then delivered with no error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_valid | input | 1 | A received coded bit is present |
| sym_bit | input | 1 | Received hard-decision coded bit |
| dec_done | input | 1 | Decoder has finished and resynchronised |
| dec_state | input | 6 | Decoder's final encoder state, bit 0 = newest stage |
| msg_valid | output | 1 | Directly decoded message bit is valid |
| msg_bit | output | 1 | Directly decoded message bit |
| err_flag | output | 1 | One-cycle pulse: estimates disagreed, decoder woken |
| dec_active | output | 1 | Decoder should be running (awake mode) |
| dec_pvalid | output | 1 | A pair is presented to the decoder |
| dec_pair | output | 2 | Pair to decoder, bit 0 lower, bit 1 upper |
| wake_cnt | output | CNT_W | Saturating count of wake-ups |

## Verification
The direct path is exercised with clean runs of constant, alternating and random message bits. A wrong tap or a wrong shift direction corrupts later bits, so these runs separate a correct inverse from one that only works for the first pair. Single-bit flips are injected in the lower bit and in the upper bit. They are placed at the very first pair, before the history has wrapped and after it has wrapped, which separates replay length, replay order and pointer wrap faults. Pairs sent during awake mode, some of them corrupted, check the live forwarding and show that errors are ignored in that mode. An early completion checks that pending pairs are dropped, and a long series of wake-ups checks counter saturation. A double flip shows the limit of the check: an error that escapes detection.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
   localparam int STAGES = 6;
   // bit i of the register is stage i+1 (bit 0 = newest)
   localparam logic [STAGES-1:0] TAP_LO = 6'b100111; // stages 1,2,3,6
   localparam logic [STAGES-1:0] TAP_HI = 6'b110110; // stages 2,3,5,6

   typedef logic [1:0] pair_t; // [0] lower, [1] upper

   typedef enum logic {ST_BYPASS = 1'b0, ST_AWAKE = 1'b1} mode_e;

   function automatic logic tap_parity(input logic [STAGES-1:0] sr,
                                       input logic [STAGES-1:0] mask);
      return ^(sr & mask);
   endfunction
endpackage

// File: rtl/cbd_pair_asm.sv
module cbd_pair_asm
   import cbd_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sym_valid,
   input  logic  sym_bit,
   output logic  pair_valid,
   output pair_t pair
);
   logic phase_q;
   logic lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         lo_q    <= 1'b0;
      end else if (sym_valid) begin
         phase_q <= ~phase_q;
         if (!phase_q) lo_q <= sym_bit;
      end
   end

   assign pair_valid = sym_valid & phase_q;
   assign pair       = {sym_bit, lo_q};

   // a completed pair always leaves the assembler waiting for a lower bit
   assert_pair_realign_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |=> !phase_q);
endmodule

// File: rtl/cbd_inverse.sv
module cbd_inverse
   import cbd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pair_valid,
   input  pair_t             pair,
   input  logic              awake,
   input  logic              load,
   input  logic [STAGES-1:0] load_state,
   output logic              mismatch,
   output logic              msg_valid,
   output logic              msg_bit
);
   logic [STAGES-1:0] sr_q;
   logic              est_lo;
   logic              est_hi;

   assign est_lo   = pair[0] ^ tap_parity(sr_q, TAP_LO);
   assign est_hi   = pair[1] ^ tap_parity(sr_q, TAP_HI);
   assign mismatch = pair_valid & (est_lo ^ est_hi);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q      <= '0;
         msg_valid <= 1'b0;
         msg_bit   <= 1'b0;
      end else begin
         msg_valid <= 1'b0;
         if (load) begin
            sr_q <= load_state;
         end else if (pair_valid && !awake && !(est_lo ^ est_hi)) begin
            sr_q      <= {sr_q[STAGES-2:0], est_lo};
            msg_valid <= 1'b1;
            msg_bit   <= est_lo;
         end
      end
   end

   assert_no_bypass_when_awake_R6: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !awake);

   assert_msg_single_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> !msg_valid);
endmodule

// File: rtl/cbd_hist_buf.sv
module cbd_hist_buf
   import cbd_pkg::*;
#(
   parameter int DEPTH = 32
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  pair_t wr_data,
   input  logic  start,
   input  logic  awake,
   input  logic  stop,
   output logic  out_valid,
   output pair_t out_pair
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cbd_hist_buf: DEPTH must be a power of two, at least 2");
   end

   pair_t          mem [DEPTH];
   logic [AW-1:0]  wr_ptr;
   logic [AW-1:0]  rd_ptr;
   logic [CW-1:0]  fill_q;
   logic [CW-1:0]  fill_nxt;
   logic [CW-1:0]  pend_q;
   logic           do_rd;

   assign fill_nxt = (wr_en && fill_q != FULL) ? fill_q + 1'b1 : fill_q;
   assign do_rd    = awake && (pend_q != '0) && !stop;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         fill_q    <= '0;
         pend_q    <= '0;
         out_valid <= 1'b0;
         out_pair  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         fill_q    <= fill_nxt;
         out_valid <= do_rd;
         if (do_rd) begin
            out_pair <= mem[rd_ptr];
            rd_ptr   <= rd_ptr + 1'b1;
         end
         if (start) begin
            pend_q <= fill_nxt;
            rd_ptr <= wr_ptr + 1'b1 - fill_nxt[AW-1:0];
         end else if (stop) begin
            pend_q <= '0;
         end else if (awake) begin
            pend_q <= pend_q + CW'(wr_en) - CW'(do_rd);
         end
      end
   end

   assert_pend_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q <= FULL);

   assert_replay_only_awake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(awake));

   assert_drop_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !out_valid);
endmodule

// File: rtl/cbd_wake_ctl.sv
module cbd_wake_ctl
   import cbd_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mismatch,
   input  logic             dec_done,
   output logic             awake,
   output logic             start,
   output logic             err_flag,
   output logic [CNT_W-1:0] wake_cnt
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("cbd_wake_ctl: CNT_W must be at least 1");
   end

   mode_e mode_q;

   assign awake = (mode_q == ST_AWAKE);
   assign start = mismatch && !awake;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= ST_BYPASS;
         err_flag <= 1'b0;
         wake_cnt <= '0;
      end else begin
         err_flag <= start;
         if (start) begin
            mode_q <= ST_AWAKE;
            if (wake_cnt != {CNT_W{1'b1}}) wake_cnt <= wake_cnt + 1'b1;
         end else if (awake && dec_done) begin
            mode_q <= ST_BYPASS;
         end
      end
   end

   assert_err_wakes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> awake);

   assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> !err_flag);

   assert_cnt_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_cnt >= $past(wake_cnt));

   assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(awake) |-> ((wake_cnt == CNT_W'($past(wake_cnt) + 1'b1)) || (&wake_cnt)));
endmodule

// File: rtl/cc_bypass_detect.sv
module cc_bypass_detect
   import cbd_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int CNT_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sym_valid,
   input  logic                      sym_bit,
   input  logic                      dec_done,
   input  logic [cbd_pkg::STAGES-1:0] dec_state,
   output logic                      msg_valid,
   output logic                      msg_bit,
   output logic                      err_flag,
   output logic                      dec_active,
   output logic                      dec_pvalid,
   output logic [1:0]                dec_pair,
   output logic [CNT_W-1:0]          wake_cnt
);
   logic  pair_valid;
   pair_t pair;
   logic  mismatch;
   logic  awake;
   logic  start;
   logic  load;
   pair_t out_pair;

   assign load       = awake && dec_done;
   assign dec_active = awake;
   assign dec_pair   = out_pair;

   cbd_pair_asm u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .sym_valid  (sym_valid),
      .sym_bit    (sym_bit),
      .pair_valid (pair_valid),
      .pair       (pair)
   );

   cbd_inverse u_inv (
      .clk        (clk),
      .rst_n      (rst_n),
      .pair_valid (pair_valid),
      .pair       (pair),
      .awake      (awake),
      .load       (load),
      .load_state (dec_state),
      .mismatch   (mismatch),
      .msg_valid  (msg_valid),
      .msg_bit    (msg_bit)
   );

   cbd_wake_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .mismatch (mismatch),
      .dec_done (dec_done),
      .awake    (awake),
      .start    (start),
      .err_flag (err_flag),
      .wake_cnt (wake_cnt)
   );

   cbd_hist_buf #(.DEPTH(DEPTH)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (pair_valid),
      .wr_data   (pair),
      .start     (start),
      .awake     (awake),
      .stop      (load),
      .out_valid (dec_pvalid),
      .out_pair  (out_pair)
   );

   assert_no_msg_and_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(msg_valid && err_flag));
endmodule

// File: tb/cc_bypass_detect_tb_top.sv
module cc_bypass_detect_tb_top;
   localparam int CLK_P    = 10;
   localparam int DEPTH_TB = 8;
   localparam int CNT_TB   = 5;
   localparam logic [5:0] M_LO = 6'b100111;
   localparam logic [5:0] M_HI = 6'b110110;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sym_valid = 1'b0;
   logic sym_bit = 1'b0;
   logic dec_done = 1'b0;
   logic [5:0] dec_state = '0;
   logic msg_valid, msg_bit, err_flag, dec_active, dec_pvalid;
   logic [1:0] dec_pair;
   logic [CNT_TB-1:0] wake_cnt;

   int n_chk = 0;
   int n_err = 0;
   logic [5:0] enc_sr;
   logic [1:0] hist [0:4095];
   logic [1:0] cap  [0:4095];
   int n_pairs, n_cap, err_idx, wake_exp;
   bit in_awake;

   always #(CLK_P/2) clk = ~clk;

   cc_bypass_detect #(.DEPTH(DEPTH_TB), .CNT_W(CNT_TB)) dut_i (
      .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_bit(sym_bit),
      .dec_done(dec_done), .dec_state(dec_state), .msg_valid(msg_valid),
      .msg_bit(msg_bit), .err_flag(err_flag), .dec_active(dec_active),
      .dec_pvalid(dec_pvalid), .dec_pair(dec_pair), .wake_cnt(wake_cnt)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor: collect decoder-side pairs, police bypass output in awake mode
   always @(negedge clk) begin
      if (rst_n && dec_pvalid) begin
         cap[n_cap] = dec_pair;
         n_cap++;
      end
      if (rst_n && msg_valid && dec_active)
         check(1'b0, "R6 msg_valid while awake", 1, 0);
   end

   task automatic do_reset();
      rst_n = 1'b0; sym_valid = 1'b0; dec_done = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      enc_sr = '0; n_pairs = 0; n_cap = 0; wake_exp = 0; in_awake = 0; err_idx = 0;
   endtask

   task automatic send_pair(input bit m, input bit [1:0] flip);
      logic [1:0] p;
      p[0] = m ^ (^(enc_sr & M_LO));
      p[1] = m ^ (^(enc_sr & M_HI));
      p = p ^ flip;
      hist[n_pairs] = p;
      n_pairs++;
      enc_sr = {enc_sr[4:0], m};
      @(negedge clk); sym_valid = 1'b1; sym_bit = p[0];
      @(negedge clk); sym_bit = p[1];
      @(negedge clk); sym_valid = 1'b0;
      if (in_awake) begin
         check(msg_valid == 1'b0, "R6 no bypass output", msg_valid, 0);
         check(err_flag == 1'b0, "R6 no flag while awake", err_flag, 0);
      end else if (flip == 2'b00 || flip == 2'b11) begin
         check(msg_valid == 1'b1, "R1 msg_valid", msg_valid, 1);
         check(msg_bit == (m ^ flip[0]), (flip == 2'b11) ? "R10 escaped bit" : "R2 msg_bit",
               msg_bit, m ^ flip[0]);
         check(err_flag == 1'b0, "R1 no flag", err_flag, 0);
      end else begin
         if (wake_exp < (1 << CNT_TB) - 1) wake_exp++;
         check(err_flag == 1'b1, "R3 err_flag", err_flag, 1);
         check(dec_active == 1'b1, "R3 dec_active", dec_active, 1);
         check(msg_valid == 1'b0, "R3 no msg", msg_valid, 0);
         check(int'(wake_cnt) == wake_exp, "R8 wake_cnt", wake_cnt, wake_exp);
         in_awake = 1;
         err_idx = n_pairs;
      end
   endtask

   task automatic finish_wake();
      int first, want, waited;
      first = err_idx - ((err_idx < DEPTH_TB) ? err_idx : DEPTH_TB);
      want = n_pairs - first;
      waited = 0;
      while (n_cap < want && waited < 200) begin @(negedge clk); waited++; end
      repeat (3) @(negedge clk);
      check(n_cap == want, "R4 replay length", n_cap, want);
      for (int i = 0; i < want && i < n_cap; i++)
         check(cap[i] == hist[first + i], (i >= err_idx - first) ? "R5 live pair" : "R4 replay pair",
               cap[i], hist[first + i]);
      n_cap = 0;
      dec_done = 1'b1; dec_state = enc_sr;
      @(negedge clk); dec_done = 1'b0;
      check(dec_active == 1'b0, "R7 dec_active falls", dec_active, 0);
      check(int'(wake_cnt) == wake_exp, "R8 wake_cnt", wake_cnt, wake_exp);
      in_awake = 0;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      @(negedge clk);
      // R9: reset state
      check(msg_valid == 0 && err_flag == 0 && dec_active == 0 && dec_pvalid == 0,
            "R9 outputs idle", {msg_valid, err_flag, dec_active, dec_pvalid}, 0);
      check(wake_cnt == 0, "R9 wake_cnt", wake_cnt, 0);

      // R4: error on first pair, replay of exactly one pair
      send_pair(1'b1, 2'b01);
      finish_wake();

      // R1/R2: constant then alternating runs
      for (int i = 0; i < 6; i++) send_pair(1'b1, 2'b00);
      for (int i = 0; i < 6; i++) send_pair(i[0], 2'b00);

      // R4: wrapped history, upper-bit error
      send_pair(1'b0, 2'b10);
      finish_wake();

      // R5/R6: live pairs during awake, one of them corrupted
      send_pair(1'b1, 2'b01);
      send_pair(1'b0, 2'b00);
      send_pair(1'b1, 2'b10);
      send_pair(1'b1, 2'b00);
      finish_wake();
      for (int i = 0; i < 3; i++) send_pair(1'b0, 2'b00);

      // R7: completion before any replay, pending pairs dropped
      send_pair(1'b1, 2'b01);
      dec_done = 1'b1; dec_state = enc_sr;
      @(negedge clk); dec_done = 1'b0;
      check(dec_active == 1'b0, "R7 early done", dec_active, 0);
      repeat (4) @(negedge clk);
      check(n_cap == 0, "R7 pending dropped", n_cap, 0);
      in_awake = 0;
      send_pair(1'b1, 2'b00);
      send_pair(1'b0, 2'b00);

      // random traffic with occasional single-bit errors
      for (int i = 0; i < 300; i++) begin
         bit m;
         int r;
         m = 1'($urandom);
         r = int'($urandom % 12);
         if (r == 0) begin
            send_pair(m, ($urandom % 2) ? 2'b01 : 2'b10);
            for (int k = 0; k < int'($urandom % 4); k++)
               send_pair(1'($urandom), ($urandom % 3 == 0) ? 2'b01 : 2'b00);
            finish_wake();
         end else begin
            send_pair(m, 2'b00);
         end
      end

      // R8: saturation
      for (int i = 0; i < 40; i++) begin
         send_pair(1'($urandom), 2'b01);
         finish_wake();
      end
      check(wake_cnt == {CNT_TB{1'b1}}, "R8 saturated", wake_cnt, (1 << CNT_TB) - 1);

      // R10: double corruption escapes detection
      send_pair(1'b0, 2'b00);
      send_pair(1'b1, 2'b11);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule